// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that hangs off a shared timer counter. On every clock it compares the counter value with a programmable compare value. It then updates a registered reference level according to a 3-bit mode taken from a control byte. The eight modes are:

- hold the level (frozen);
- set, clear or invert the level when the counter equals the compare value;
- force the level low or high;
- two PWM shapes, which are the inverse of each other and which look at the count direction.

The channel also keeps a sticky match flag for an interrupt controller. Software clears the flag with a write-one strobe.

The counter, its reload logic and its direction come from outside. The direction is given as one bit, where 1 means the counter is counting down. A channel-enable input freezes both the reference level and the flag-setting path. While the channel is disabled, only the clear strobe still acts.

Top module: `oc_channel`

## Requirements
- R1: After reset, `ref_o` and `match_flag_o` are 0.
- R2: The mode is `ctrl_i[6:4]`: 0 frozen, 1 set-on-match, 2 clear-on-match, 3 toggle-on-match, 4 force low, 5 force high, 6 PWM-A, 7 PWM-B. `ctrl_i[7]` and `ctrl_i[3:0]` have no effect.
- R3: In frozen mode `ref_o` keeps its level, even when the counter equals the compare value.
- R4: In set-on-match mode, `ref_o` goes to 1 on the edge where `cnt_i == cmp_i`. In clear-on-match mode it goes to 0 on that edge. On every other edge it holds.
- R5: In toggle mode, `ref_o` inverts on each edge where `cnt_i == cmp_i` and holds otherwise.
- R6: Mode 4 drives `ref_o` to 0 and mode 5 drives it to 1 on the next edge, whatever the counter value.
- R7: PWM-A: when `cnt_down_i` is 0, `ref_o` becomes 1 if `cnt_i < cmp_i` and 0 otherwise. When `cnt_down_i` is 1, `ref_o` becomes 0 if `cnt_i > cmp_i` and 1 otherwise.
- R8: PWM-B produces the inverse of the PWM-A level in both directions.
- R9: While `chan_en_i` is 0, `ref_o` holds its level in every mode and `match_flag_o` is not set.
- R10: With the channel enabled and `cnt_i == cmp_i`, `match_flag_o` is 1 from the next edge on. It stays 1 until a cycle with `flag_clr_i` high. If a clear and a match happen in the same cycle, the flag stays set.
- R11: A mode change takes effect on the very next edge. In PWM-A up-counting, a compare value above the reload value keeps `ref_o` at 1 for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared counter value |
| cnt_down_i | input | 1 | Count direction, 1 = counting down |
| cmp_i | input | 16 | Channel compare value |
| ctrl_i | input | 8 | Control byte, mode in bits [6:4] |
| chan_en_i | input | 1 | Channel enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the match flag |
| ref_o | output | 1 | Registered reference level |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
On every cycle, the assertions check the following:
- the forced levels;
- holding in frozen and disabled states;
- inversion on a toggle match;
- the PWM-A up-count level;
- setting and clearing of the flag.

Only the bench's scenarios can show that whole waveforms are right. This covers toggle periods across several counter wraps, PWM-A and PWM-B shapes in both directions, and a compare value past the reload value. It also covers ignored control bits and a mode switch in the middle of a period. For these, the bench checks outputs against a behavioural model over long runs.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN   = 3'd0,
    OC_SET_HIT  = 3'd1,
    OC_CLR_HIT  = 3'd2,
    OC_TGL_HIT  = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM_A    = 3'd6,
    OC_PWM_B    = 3'd7
  } oc_mode_e;

  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned MODE_W   = 3;
endpackage

// File: rtl/oc_match.sv
module oc_match #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         eq_o,
  output logic         lt_o,
  output logic         gt_o
);
  always_comb begin
    eq_o = (cnt_i == cmp_i);
    lt_o = (cnt_i <  cmp_i);
    gt_o = (cnt_i >  cmp_i);
  end
endmodule

// File: rtl/oc_ref.sv
module oc_ref
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  oc_mode_e mode_i,
  input  logic     down_i,
  input  logic     eq_i,
  input  logic     lt_i,
  input  logic     gt_i,
  output logic     ref_o
);
  logic ref_q, ref_d, ref_ce, pwm_lvl;

  always_comb begin
    pwm_lvl = down_i ? ~gt_i : lt_i;
    ref_d   = ref_q;
    unique case (mode_i)
      OC_FROZEN:   ref_d = ref_q;
      OC_SET_HIT:  ref_d = eq_i ? 1'b1 : ref_q;
      OC_CLR_HIT:  ref_d = eq_i ? 1'b0 : ref_q;
      OC_TGL_HIT:  ref_d = eq_i ? ~ref_q : ref_q;
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM_A:    ref_d = pwm_lvl;
      OC_PWM_B:    ref_d = ~pwm_lvl;
      default:     ref_d = ref_q;
    endcase
    ref_ce = en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= 1'b0;
    else if (ref_ce) ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  // R9
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(ref_q));
  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OC_FROZEN) |=> $stable(ref_q));
  // R6
  force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == OC_FORCE_HI) |=> ref_q);
  // R6
  force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == OC_FORCE_LO) |=> !ref_q);
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == OC_TGL_HIT && eq_i) |=> (ref_q != $past(ref_q)));
  // R7
  pwm_a_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == OC_PWM_A && !down_i && lt_i) |=> ref_q);
endmodule

// File: rtl/oc_flag.sv
module oc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_ce;

  always_comb begin
    flag_ce = hit_i | clr_i;
    flag_d  = hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_q);
  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !flag_q);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      cnt_i,
  input  logic              cnt_down_i,
  input  logic [W-1:0]      cmp_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              chan_en_i,
  input  logic              flag_clr_i,
  output logic              ref_o,
  output logic              match_flag_o
);
  localparam int unsigned MODE_MSB = MODE_LSB + MODE_W - 1;

  logic     eq, lt, gt, hit;
  oc_mode_e mode;

  always_comb begin
    mode = oc_mode_e'(ctrl_i[MODE_MSB:MODE_LSB]);
    hit  = chan_en_i & eq;
  end

  oc_match #(.W(W)) u_match (
    .cnt_i (cnt_i),
    .cmp_i (cmp_i),
    .eq_o  (eq),
    .lt_o  (lt),
    .gt_o  (gt)
  );

  oc_ref u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (chan_en_i),
    .mode_i (mode),
    .down_i (cnt_down_i),
    .eq_i   (eq),
    .lt_i   (lt),
    .gt_i   (gt),
    .ref_o  (ref_o)
  );

  oc_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .clr_i  (flag_clr_i),
    .flag_o (match_flag_o)
  );

  // R2
  ctrl_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(ctrl_i));
  // R9
  dis_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en_i && !match_flag_o) |=> !match_flag_o);
endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        cnt_down_i = 1'b0;
  logic [15:0] cmp_i = '0;
  logic [7:0]  ctrl_i = '0;
  logic        chan_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic        ref_o, match_flag_o;

  int    errors = 0;
  int    checks = 0;
  bit    exp_ref = 0;
  bit    exp_flag = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  oc_channel i_oc_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
    .cmp_i(cmp_i), .ctrl_i(ctrl_i), .chan_en_i(chan_en_i),
    .flag_clr_i(flag_clr_i), .ref_o(ref_o), .match_flag_o(match_flag_o)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_ref = 0;
      exp_flag = 0;
    end else begin
      int  m;
      int  c;
      int  k;
      bit  hitv;
      bit  lvl;
      m = int'(ctrl_i[6:4]);
      c = int'(cnt_i);
      k = int'(cmp_i);
      hitv = (c == k);
      lvl = cnt_down_i ? !(c > k) : (c < k);
      if (chan_en_i) begin
        case (m)
          1: if (hitv) exp_ref = 1;
          2: if (hitv) exp_ref = 0;
          3: if (hitv) exp_ref = !exp_ref;
          4: exp_ref = 0;
          5: exp_ref = 1;
          6: exp_ref = lvl;
          7: exp_ref = !lvl;
          default: ;
        endcase
      end
      if (chan_en_i && hitv) exp_flag = 1;
      else if (flag_clr_i) exp_flag = 0;
    end
  end

  task automatic check(string req, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(cur_req, ref_o, exp_ref, "ref_o");
      check(cur_req, match_flag_o, exp_flag, "match_flag_o");
    end
  end

  task automatic run_count(int reload, bit down, int periods);
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i <= reload; i++) begin
        @(negedge clk);
        cnt_down_i = down;
        cnt_i = down ? 16'(reload - i) : 16'(i);
      end
    end
  endtask

  task automatic set_mode(int m, bit junk);
    @(negedge clk);
    ctrl_i = {junk, 3'(m), junk ? 4'hF : 4'h0};
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr_i = 1;
    @(negedge clk);
    flag_clr_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", ref_o, 1'b0, "reset ref_o");
    check("R1", match_flag_o, 1'b0, "reset match_flag_o");
    cmp_on = 1;
    chan_en_i = 1;
    cmp_i = 16'd5;

    cur_req = "R4"; set_mode(1, 0); run_count(9, 0, 2);
    cur_req = "R10"; clear_flag();
    cur_req = "R4"; set_mode(2, 0); run_count(9, 0, 2);
    cur_req = "R3"; set_mode(5, 0); @(negedge clk); set_mode(0, 0); run_count(9, 0, 2);
    cur_req = "R5"; set_mode(3, 0); run_count(9, 0, 3); run_count(9, 1, 2);
    cur_req = "R6"; set_mode(4, 0); run_count(9, 0, 1);
    set_mode(5, 0); run_count(9, 1, 1);
    cur_req = "R7"; cmp_i = 16'd6; set_mode(6, 0); run_count(11, 0, 2); run_count(11, 1, 2);
    cur_req = "R8"; set_mode(7, 0); run_count(11, 0, 2); run_count(11, 1, 2);
    cur_req = "R2"; set_mode(6, 1); run_count(11, 0, 1); set_mode(3, 1); run_count(11, 1, 2);
    cur_req = "R11"; cmp_i = 16'd20; set_mode(6, 0); run_count(11, 0, 2);
    for (int m = 0; m < 8; m++) begin
      set_mode(m, 0); run_count(3, 0, 1);
    end
    // R9: disabled channel ignores matches and forced levels
    cur_req = "R9"; cmp_i = 16'd3; set_mode(3, 0); clear_flag();
    @(negedge clk); chan_en_i = 0;
    set_mode(5, 0); run_count(7, 0, 1);
    set_mode(4, 0); run_count(7, 1, 1);
    set_mode(3, 0); run_count(7, 0, 1);
    chan_en_i = 1;
    // R10: clear and match in the same cycle keep the flag set
    cur_req = "R10"; clear_flag(); run_count(7, 0, 1);
    @(negedge clk); cnt_i = 16'd3; flag_clr_i = 1;
    @(negedge clk); flag_clr_i = 0; cnt_i = 16'd4;
    @(negedge clk);
    check("R10", match_flag_o, 1'b1, "set wins over clear");
    clear_flag(); @(negedge clk);
    check("R10", match_flag_o, 1'b0, "flag cleared");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule